// File: doc/BRIEF.md
# Interrupt and Cycle-Steal Priority Arbiter

This block decides, at every instruction boundary of a small control processor, which pending activity takes control. The activities are six interrupt levels, two kinds of cycle-steal request (burst and base) and the main program level, which is always present and has the lowest priority. The order is fixed. Level 0 comes first. The two cycle-steal kinds sit just below level 0, and levels 1 through 5 follow in turn. A cycle steal is a one-cycle grant. The interrupted level keeps running after it.

When an interrupt level is entered, the arbiter pushes the level it leaves onto an internal stack. It raises a one-cycle pulse telling the processor to save the shared condition register. A level-exit at an instruction boundary pops the stack and returns control to the interrupted level, with a one-cycle pulse to restore the condition register. The arbiter also drives a register-set select code for the local storage that holds each level's working registers. It only produces selection and control. The datapath and the register storage are outside the block.

Top module: `irq_cs_arbiter`

## Requirements
- R1: At an instruction boundary the winner is the first eligible entry in this order: level 0, burst steal, base steal, then levels 1, 2, 3, 4 and 5. While level 0 is active, neither kind of cycle steal is granted.
- R2: A granted cycle steal raises `cs_burst_gnt` or `cs_base_gnt` for exactly one cycle. It leaves `cur_level` unchanged and raises neither `cr_save` nor `cr_restore`.
- R3: An interrupt request is eligible only if its level number is strictly lower than the active level, with the main program level coded 6. A request at the same or a lower priority leaves the level unchanged.
- R4: `level_exit` at a boundary returns control to the most recently interrupted level, and the stack nests in order. While the main program level is active, `level_exit` has no effect, and arbitration at that boundary proceeds normally.
- R5: When a pop is possible, an exit at a boundary takes precedence over every request at that same boundary. No entry and no steal happens in that cycle.
- R6: `regset_sel` is 0 for both the main program level and level 0. For levels 1 to 5 it equals the level number. `main_active` is 1 exactly when `cur_level` is 6.
- R7: Entering an interrupt level raises `cr_save` for exactly one cycle, in the cycle in which `cur_level` shows the new level.
- R8: Leaving a level raises `cr_restore` for exactly one cycle, in the cycle in which `cur_level` shows the resumed level.
- R9: Without `insn_boundary`, no input changes `cur_level`, and no grant, save or restore pulse is produced.
- R10: After reset, `cur_level` is 6 (main program level), the stack is empty and every pulse output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 6 | Level-sensitive interrupt requests; bit n is level n |
| cs_burst_req | input | 1 | Burst cycle-steal request |
| cs_base_req | input | 1 | Base cycle-steal request |
| insn_boundary | input | 1 | Instruction boundary strobe; decisions are taken only here |
| level_exit | input | 1 | Current level finishes (acted on with `insn_boundary`) |
| cur_level | output | 3 | Active level: 0..5 interrupt level, 6 main program |
| main_active | output | 1 | Main program level is active |
| regset_sel | output | 3 | Local storage register-set select code |
| cr_save | output | 1 | One-cycle condition-register save pulse |
| cr_restore | output | 1 | One-cycle condition-register restore pulse |
| cs_burst_gnt | output | 1 | One-cycle burst cycle-steal grant |
| cs_base_gnt | output | 1 | One-cycle base cycle-steal grant |

## Verification
The assertions check the following on every cycle:
- A save only ever moves control to a higher-priority level.
- A restore only ever moves control to a lower-priority level.
- A steal never moves the level.
- At most one event pulse is high at a time.
- Nothing changes without a boundary strobe.
- The select code agrees with the active level.

Some behaviours only the bench scenarios can show, by comparing against its stack-based model:
- Which contender actually wins.
- The exit-over-entry precedence.
- The exact level returned to after nested interrupts.
- That an exit in the main program level is harmless.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  // Kind of decision taken at an instruction boundary
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_ENTER = 2'd1,
    ACT_EXIT  = 2'd2,
    ACT_STEAL = 2'd3
  } act_e;
endpackage

// File: rtl/irqa_prio_pick.sv
module irqa_prio_pick #(
  parameter int unsigned NUM_LVL  = 6,
  parameter int unsigned CS_AFTER = 1,
  localparam int unsigned LW      = $clog2(NUM_LVL + 1)
) (
  input  logic [NUM_LVL-1:0] irq_req,
  input  logic               burst_req,
  input  logic               base_req,
  input  logic [LW-1:0]      cur_lvl,
  output logic               irq_go,
  output logic [LW-1:0]      irq_lvl,
  output logic               burst_go,
  output logic               base_go
);
  localparam logic [NUM_LVL-1:0] HI_MASK = NUM_LVL'((1 << CS_AFTER) - 1);

  logic [NUM_LVL-1:0] elig;
  logic               irq_win;
  logic               cs_ok;

  // A level may preempt only if it outranks the active one (lower code)
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_elig
    assign elig[l] = irq_req[l] && (LW'(l) < cur_lvl);
  end

  always_comb begin
    irq_win = 1'b0;
    irq_lvl = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (elig[l]) begin
        irq_win = 1'b1;
        irq_lvl = LW'(l);
      end
    end
  end

  // Steals rank below levels under CS_AFTER and above the rest
  assign cs_ok    = (cur_lvl >= LW'(CS_AFTER)) && !(|(elig & HI_MASK));
  assign burst_go = cs_ok && burst_req;
  assign base_go  = cs_ok && !burst_req && base_req;
  assign irq_go   = irq_win && !burst_go && !base_go;
endmodule

// File: rtl/irqa_level_stack.sv
module irqa_level_stack #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned LW    = 3,
  localparam int unsigned SPW  = $clog2(DEPTH + 1),
  localparam int unsigned SLOTS = 1 << SPW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [LW-1:0] push_data,
  output logic [LW-1:0] top_data,
  output logic          empty
);
  logic [LW-1:0]  mem [SLOTS];
  logic [SPW-1:0] sp_q, sp_d;
  logic [SPW-1:0] top_idx;

  assign top_idx  = sp_q - SPW'(1);
  assign top_data = mem[top_idx];
  assign empty    = (sp_q == '0);

  always_comb begin
    sp_d = sp_q;
    if (push)              sp_d = sp_q + SPW'(1);
    else if (pop && !empty) sp_d = sp_q - SPW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  // Entry storage carries no reset; only the pointer defines validity
  always_ff @(posedge clk) begin
    if (push) mem[sp_q] <= push_data;
  end
endmodule

// File: rtl/irq_cs_arbiter.sv
module irq_cs_arbiter #(
  parameter int unsigned NUM_LVL  = 6,
  parameter int unsigned CS_AFTER = 1,
  localparam int unsigned LW      = $clog2(NUM_LVL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] irq_req,
  input  logic               cs_burst_req,
  input  logic               cs_base_req,
  input  logic               insn_boundary,
  input  logic               level_exit,
  output logic [LW-1:0]      cur_level,
  output logic               main_active,
  output logic [LW-1:0]      regset_sel,
  output logic               cr_save,
  output logic               cr_restore,
  output logic               cs_burst_gnt,
  output logic               cs_base_gnt
);
  import irqa_pkg::*;

  localparam logic [LW-1:0] MAIN_CODE = LW'(NUM_LVL);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // arbitration
  logic          irq_go, burst_go, base_go;
  logic [LW-1:0] irq_lvl;
  logic [LW-1:0] cur_q, cur_d;
  logic          stk_push, stk_pop, stk_empty;
  logic [LW-1:0] stk_top;
  act_e          act;
  logic          save_q, save_d, rest_q, rest_d;
  logic          bgnt_q, bgnt_d, sgnt_q, sgnt_d;

  irqa_prio_pick #(.NUM_LVL(NUM_LVL), .CS_AFTER(CS_AFTER)) u_pick (
    .irq_req   (irq_req),
    .burst_req (cs_burst_req),
    .base_req  (cs_base_req),
    .cur_lvl   (cur_q),
    .irq_go    (irq_go),
    .irq_lvl   (irq_lvl),
    .burst_go  (burst_go),
    .base_go   (base_go)
  );

  irqa_level_stack #(.DEPTH(NUM_LVL), .LW(LW)) u_stack (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (stk_push),
    .pop       (stk_pop),
    .push_data (cur_q),
    .top_data  (stk_top),
    .empty     (stk_empty)
  );

  // decision: an exit that can pop outranks all requests at the boundary
  always_comb begin
    act = ACT_NONE;
    if (insn_boundary) begin
      if (level_exit && !stk_empty)      act = ACT_EXIT;
      else if (irq_go)                   act = ACT_ENTER;
      else if (burst_go || base_go)      act = ACT_STEAL;
    end
  end

  always_comb begin
    cur_d    = cur_q;
    stk_push = 1'b0;
    stk_pop  = 1'b0;
    save_d   = 1'b0;
    rest_d   = 1'b0;
    bgnt_d   = 1'b0;
    sgnt_d   = 1'b0;
    unique case (act)
      ACT_ENTER: begin
        stk_push = 1'b1;
        cur_d    = irq_lvl;
        save_d   = 1'b1;
      end
      ACT_EXIT: begin
        stk_pop  = 1'b1;
        cur_d    = stk_top;
        rest_d   = 1'b1;
      end
      ACT_STEAL: begin
        bgnt_d   = burst_go;
        sgnt_d   = base_go;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cur_q  <= MAIN_CODE;
      save_q <= 1'b0;
      rest_q <= 1'b0;
      bgnt_q <= 1'b0;
      sgnt_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      save_q <= save_d;
      rest_q <= rest_d;
      bgnt_q <= bgnt_d;
      sgnt_q <= sgnt_d;
    end
  end

  assign cur_level    = cur_q;
  assign main_active  = (cur_q == MAIN_CODE);
  assign regset_sel   = main_active ? '0 : cur_q;
  assign cr_save      = save_q;
  assign cr_restore   = rest_q;
  assign cs_burst_gnt = bgnt_q;
  assign cs_base_gnt  = sgnt_q;
endmodule

// File: rtl/irqa_checker.sv
module irqa_checker #(
  parameter int unsigned NUM_LVL = 6,
  localparam int unsigned LW     = $clog2(NUM_LVL + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          insn_boundary,
  input logic [LW-1:0] cur_level,
  input logic          main_active,
  input logic [LW-1:0] regset_sel,
  input logic          cr_save,
  input logic          cr_restore,
  input logic          cs_burst_gnt,
  input logic          cs_base_gnt
);
  a_r1_level_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cur_level <= LW'(NUM_LVL));

  a_r2_steal_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_burst_gnt || cs_base_gnt) |-> (cur_level == $past(cur_level)));

  a_r2_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_burst_gnt, cs_base_gnt, cr_save, cr_restore}));

  a_r7_save_raises_priority: assert property (@(posedge clk) disable iff (!rst_n)
    cr_save |-> (cur_level < $past(cur_level)));

  a_r8_restore_lowers_priority: assert property (@(posedge clk) disable iff (!rst_n)
    cr_restore |-> (cur_level > $past(cur_level)));

  a_r9_quiet_without_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(insn_boundary) |->
      ($stable(cur_level) && !cr_save && !cr_restore && !cs_burst_gnt && !cs_base_gnt));

  a_r6_select_code: assert property (@(posedge clk) disable iff (!rst_n)
    (main_active == (cur_level == LW'(NUM_LVL))) &&
    (regset_sel == (main_active ? '0 : cur_level)));
endmodule

bind irq_cs_arbiter irqa_checker #(.NUM_LVL(NUM_LVL)) u_irqa_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .insn_boundary (insn_boundary),
  .cur_level     (cur_level),
  .main_active   (main_active),
  .regset_sel    (regset_sel),
  .cr_save       (cr_save),
  .cr_restore    (cr_restore),
  .cs_burst_gnt  (cs_burst_gnt),
  .cs_base_gnt   (cs_base_gnt)
);

// File: tb/tb_irq_cs_arbiter.sv
`timescale 1ns/1ps
module tb_irq_cs_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] irq_req = '0;
  logic       cs_burst_req = 1'b0, cs_base_req = 1'b0;
  logic       insn_boundary = 1'b0, level_exit = 1'b0;
  logic [2:0] cur_level, regset_sel;
  logic       main_active, cr_save, cr_restore, cs_burst_gnt, cs_base_gnt;

  int checks = 0, fails = 0;
  bit cmp_en = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  irq_cs_arbiter dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .cs_burst_req(cs_burst_req), .cs_base_req(cs_base_req),
    .insn_boundary(insn_boundary), .level_exit(level_exit),
    .cur_level(cur_level), .main_active(main_active), .regset_sel(regset_sel),
    .cr_save(cr_save), .cr_restore(cr_restore),
    .cs_burst_gnt(cs_burst_gnt), .cs_base_gnt(cs_base_gnt)
  );

  // behavioural reference: level number, queue of interrupted levels
  int m_cur;
  int stk[$];
  bit m_save, m_rest, m_bg, m_bs;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = 6; stk.delete();
      m_save = 0; m_rest = 0; m_bg = 0; m_bs = 0;
    end else begin
      m_save = 0; m_rest = 0; m_bg = 0; m_bs = 0;
      if (insn_boundary) begin
        if (level_exit && stk.size() > 0) begin
          m_cur = stk.pop_back(); m_rest = 1;
        end else if (irq_req[0] && m_cur != 0) begin
          stk.push_back(m_cur); m_cur = 0; m_save = 1;
        end else if (m_cur != 0 && cs_burst_req) begin
          m_bg = 1;
        end else if (m_cur != 0 && cs_base_req) begin
          m_bs = 1;
        end else begin
          for (int l = 1; l < 6; l++) begin
            if (!m_save && irq_req[l] && l < m_cur) begin
              stk.push_back(m_cur); m_cur = l; m_save = 1;
            end
          end
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R1/R3/R4", "model cur_level", cur_level, m_cur);
      chk("R6", "model regset_sel", regset_sel, (m_cur == 6) ? 0 : m_cur);
      chk("R7", "model cr_save", cr_save, m_save);
      chk("R8", "model cr_restore", cr_restore, m_rest);
      chk("R2", "model burst gnt", cs_burst_gnt, m_bg);
      chk("R2", "model base gnt", cs_base_gnt, m_bs);
    end
  end

  task automatic drive(input logic [5:0] ir, input logic bu, input logic ba,
                       input logic bd, input logic ex);
    irq_req = ir; cs_burst_req = bu; cs_base_req = ba;
    insn_boundary = bd; level_exit = ex;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10", "cur_level", cur_level, 6);
    chk("R10", "main_active", main_active, 1);
    chk("R10", "pulses", {cr_save, cr_restore, cs_burst_gnt, cs_base_gnt}, 0);
    cmp_en = 1'b1;
    // R9 requests without boundary are held off
    repeat (3) drive(6'b001000, 1, 1, 0, 0);
    chk("R9", "no boundary level", cur_level, 6);
    chk("R9", "no boundary gnt", cs_burst_gnt, 0);
    drive(6'b001000, 0, 0, 1, 0);
    chk("R7", "enter 3 save", cr_save, 1);
    chk("R6", "regset level 3", regset_sel, 3);
    drive(6'b000000, 0, 0, 0, 0);
    chk("R7", "save one cycle", cr_save, 0);
    drive(6'b011000, 0, 0, 1, 0);
    chk("R3", "equal/lower waits", cur_level, 3);
    drive(6'b000000, 1, 0, 1, 0);
    chk("R2", "burst granted", cs_burst_gnt, 1);
    chk("R2", "steal keeps level", cur_level, 3);
    chk("R2", "steal no save", cr_save, 0);
    drive(6'b000000, 0, 0, 0, 0);
    chk("R2", "grant one cycle", cs_burst_gnt, 0);
    drive(6'b000010, 0, 1, 1, 0);
    chk("R1", "base steal over level 1", cs_base_gnt, 1);
    chk("R1", "level held during steal", cur_level, 3);
    drive(6'b000010, 0, 0, 1, 0);
    chk("R1", "enter level 1", cur_level, 1);
    drive(6'b000001, 1, 0, 1, 0);
    chk("R1", "level 0 over burst", cur_level, 0);
    chk("R6", "level 0 regset", regset_sel, 0);
    chk("R6", "level 0 not main", main_active, 0);
    drive(6'b000010, 1, 1, 1, 0);
    chk("R1", "no steal in level 0", cs_burst_gnt | cs_base_gnt, 0);
    drive(6'b000100, 1, 0, 1, 1);
    chk("R5", "exit beats request", cur_level, 1);
    chk("R8", "restore pulse", cr_restore, 1);
    chk("R5", "no save with exit", cr_save, 0);
    drive(6'b000000, 0, 0, 1, 1);
    chk("R4", "pop to level 3", cur_level, 3);
    drive(6'b000000, 0, 0, 1, 1);
    chk("R4", "pop to main", cur_level, 6);
    drive(6'b100000, 0, 0, 1, 1);
    chk("R4", "exit in main ignored, enter 5", cur_level, 5);
    chk("R4", "exit in main no restore", cr_restore, 0);
    drive(6'b000000, 0, 0, 0, 1);
    chk("R9", "exit without boundary", cur_level, 5);
    drive(6'b000000, 0, 0, 1, 1);
    chk("R8", "back to main", main_active, 1);
    // mixed traffic against the model
    for (int i = 0; i < 5000; i++) begin
      logic [5:0] ir;
      for (int b = 0; b < 6; b++) ir[b] = ($urandom_range(0, 5) == 0);
      drive(ir, $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
            $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0);
    end
    drive(6'b000000, 0, 0, 0, 0);
    finish_run();
  end
endmodule